// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two `WIDTH`-bit two's complement numbers over several clock cycles. It returns a `2*WIDTH`-bit signed product. Each iteration inspects the multiplier's least significant bit together with the bit shifted out on the previous iteration. From that pair it adds the multiplicand to the accumulator, subtracts it, or leaves the accumulator alone. The accumulator, multiplier and extension bit then shift right as one arithmetic register. Because the sign is handled by the recoding and the arithmetic shift, every sign combination comes out right without a correction step at the end.

A pulse on `start_i` while the block is idle captures both operands. `busy_o` stays high for the load cycle and the `WIDTH` iterations. `done_o` then rises and stays high, and the product holds steady until the next accepted start. The accumulator carries one guard bit internally. This keeps the most negative operand times itself exact.

Top module: `seq_booth_mult`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `product_o` are all zero.
- R2: A `start_i` sampled high while `busy_o` is low captures both operands. `busy_o` is high after that edge and `done_o` is low.
- R3: `done_o` rises exactly `WIDTH+1` clock edges after the edge that accepted the start. `busy_o` falls on the same edge. The two are never high together.
- R4: When `done_o` is high, `product_o` equals the signed product of the captured operands, sign-extended to `2*WIDTH` bits, for all sign combinations. The iteration pair (LSB, previous bit) selects subtract for 10, add for 01, and no change for 00 or 11.
- R5: The most negative operand times itself gives the positive value 2^(2*WIDTH-2) (0x40 for 4 bits).
- R6: A start pulse, or a change of operand inputs, while `busy_o` is high has no effect on the result or its timing.
- R7: While idle and without a start, `product_o` and `done_o` keep their values, whatever the operand inputs do.
- R8: For 4-bit operands, 7×3 gives 0x15, 7×(−3) and (−7)×3 give 0xEB, and (−7)×(−3) gives 0x15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiply; accepted only when idle |
| multiplicand_i | input | WIDTH | Signed multiplicand |
| multiplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | Product valid; held until next accepted start |
| product_o | output | 2*WIDTH | Signed product |

## Verification
Suppose the recoding picks the wrong operation, or the shift drops the sign. Then the product is already wrong when `done_o` rises, `WIDTH+1` cycles after the start. The error shows first on negative operands and on the most negative value. A wrong counter shows up as `done_o` rising on a cycle other than the expected one. If the handshake accepts a start while busy, the product belongs to the wrong operands. An exhaustive 4-bit sweep catches every recoding error. A random 16-bit run exercises long carry chains.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    BOOTH_NOP = 2'd0,
    BOOTH_ADD = 2'd1,
    BOOTH_SUB = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      q_lsb_i,
  input  logic      q_ext_i,
  output booth_op_e op_o
);
  always_comb begin
    unique case ({q_lsb_i, q_ext_i})
      2'b10:   op_o = BOOTH_SUB;
      2'b01:   op_o = BOOTH_ADD;
      default: op_o = BOOTH_NOP;
    endcase
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(WIDTH);

  logic [CNT_W-1:0] cnt_q;

  assign load_o = start_i && !busy_o;
  assign step_o = busy_o && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else if (load_o) begin
      cnt_q  <= CNT_INIT;
      busy_o <= 1'b1;
      done_o <= 1'b0;
    end else if (busy_o) begin
      if (cnt_q == '0) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int AW = WIDTH + 1;  // guard bit keeps -2^(n-1) squared exact

  logic [AW-1:0]    acc_q, mcand_q, sum;
  logic [WIDTH-1:0] q_q;
  logic             q_ext_q;
  booth_op_e        op;

  booth_recode u_recode (
    .q_lsb_i(q_q[0]),
    .q_ext_i(q_ext_q),
    .op_o   (op)
  );

  always_comb begin
    unique case (op)
      BOOTH_ADD: sum = acc_q + mcand_q;
      BOOTH_SUB: sum = acc_q - mcand_q;
      default:   sum = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      mcand_q <= '0;
      q_q     <= '0;
      q_ext_q <= 1'b0;
    end else if (load_i) begin
      acc_q   <= '0;
      mcand_q <= {mcand_i[WIDTH-1], mcand_i};
      q_q     <= mplier_i;
      q_ext_q <= 1'b0;
    end else if (step_i) begin
      {acc_q, q_q, q_ext_q} <= {sum[AW-1], sum, q_q};
    end
  end

  assign product_o = {acc_q[WIDTH-1:0], q_q};
endmodule

// File: rtl/seq_booth_mult.sv
module seq_booth_mult #(
  parameter int WIDTH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   multiplicand_i,
  input  logic [WIDTH-1:0]   multiplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic load, step;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  booth_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .mcand_i  (multiplicand_i),
    .mplier_i (multiplier_i),
    .product_o(product_o)
  );
endmodule

// File: rtl/seq_booth_mult_chk.sv
module seq_booth_mult_chk #(
  parameter int WIDTH = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [WIDTH-1:0]   multiplicand_i,
  input logic [WIDTH-1:0]   multiplier_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o
);
  localparam int CW = $clog2(WIDTH + 2) + 1;
  localparam logic [CW-1:0] LAT = CW'(WIDTH + 1);

  logic [CW-1:0] edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 edges_q <= '0;
    else if (start_i && !busy_o) edges_q <= '0;
    else if (busy_o)             edges_q <= edges_q + 1'b1;
  end

  a_r2_start_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !done_o);

  a_r3_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> edges_q == LAT);

  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  a_r6_no_spurious_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i) && !$past(busy_o));

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(product_o) && $stable(done_o));
endmodule

bind seq_booth_mult seq_booth_mult_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/seq_booth_mult_tb_top.sv
module seq_booth_mult_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        s4 = 1'b0, busy4, done4;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  p4;
  logic        s16 = 1'b0, busy16, done16;
  logic [15:0] a16 = '0, b16 = '0;
  logic [31:0] p16;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  seq_booth_mult #(.WIDTH(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s4),
    .multiplicand_i(a4), .multiplier_i(b4),
    .busy_o(busy4), .done_o(done4), .product_o(p4));

  seq_booth_mult #(.WIDTH(16)) dut16_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s16),
    .multiplicand_i(a16), .multiplier_i(b16),
    .busy_o(busy16), .done_o(done16), .product_o(p16));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // probe=1 pulses a start with other operands on the cycle after acceptance (R6)
  task automatic op4(input logic [3:0] a, input logic [3:0] b, input bit probe, input string req);
    logic [7:0] exp;
    bit early, lat;
    exp = 8'($signed({{4{a[3]}}, a}) * $signed({{4{b[3]}}, b}));
    @(negedge clk); a4 = a; b4 = b; s4 = 1'b1;
    @(negedge clk); s4 = 1'b0; lat = busy4 && !done4;
    if (probe) begin a4 = ~a; b4 = b + 4'd3; s4 = 1'b1; end
    early = 1'b0;
    repeat (4) begin @(negedge clk); s4 = 1'b0; a4 = ~a4; if (done4 || !busy4) early = 1'b1; end
    @(negedge clk);
    chk(lat, "R2", {63'd0, busy4}, 64'd1);
    chk(done4 && !busy4 && !early, probe ? "R6" : "R3", {62'd0, busy4, done4}, 64'd1);
    chk(p4 == exp, req, 64'(p4), 64'(exp));
  endtask

  task automatic op16(input logic [15:0] a, input logic [15:0] b, input string req);
    logic [31:0] exp;
    bit early;
    exp = 32'($signed({{16{a[15]}}, a}) * $signed({{16{b[15]}}, b}));
    @(negedge clk); a16 = a; b16 = b; s16 = 1'b1;
    @(negedge clk); s16 = 1'b0;
    early = 1'b0;
    repeat (16) begin @(negedge clk); if (done16) early = 1'b1; end
    @(negedge clk);
    chk(done16 && !early, "R3", {63'd0, done16}, 64'd1);
    chk(p16 == exp, req, 64'(p16), 64'(exp));
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 200000) begin @(posedge clk); cyc++; end
    n_tests++; n_fail++;
    $display("FAIL watchdog act=%0d exp=<200000", cyc);
    summary();
  end

  initial begin
    logic [7:0] held;
    // R1: reset values
    repeat (2) @(negedge clk);
    chk(!busy4 && !done4 && p4 == 8'd0, "R1", {54'd0, busy4, done4, p4}, 64'd0);
    chk(!busy16 && !done16 && p16 == 32'd0, "R1", {30'd0, busy16, done16, p16}, 64'd0);
    rst_n = 1'b1;

    // R8: worked sign cases
    op4(4'd7,        4'd3,        1'b0, "R8");
    op4(4'd7,        4'b1101,     1'b0, "R8");
    op4(4'b1001,     4'd3,        1'b0, "R8");
    op4(4'b1001,     4'b1101,     1'b0, "R8");

    // R5: most negative squared, both widths
    op4(4'b1000, 4'b1000, 1'b0, "R5");
    op16(16'h8000, 16'h8000, "R5");

    // R4: exhaustive 4-bit sweep; R6 probes interleaved
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        op4(4'(i), 4'(j), ((i + j) % 5) == 0, "R4");

    // R7: idle hold under operand churn
    held = p4;
    repeat (6) begin
      @(negedge clk); a4 = a4 + 4'd5; b4 = b4 ^ 4'hA;
      chk(p4 == held && done4, "R7", {55'd0, done4, p4}, {55'd0, 1'b1, held});
    end

    // R4: random 16-bit operands plus edge values
    op16(16'h7FFF, 16'h8000, "R4");
    op16(16'hFFFF, 16'hFFFF, "R4");
    op16(16'h0000, 16'h8001, "R4");
    for (int k = 0; k < 300; k++) op16(16'($urandom), 16'($urandom), "R4");

    summary();
  end
endmodule